// File: doc/BRIEF.md
# HDM Decoder Register Block

This block holds the software-visible configuration of one host-managed device memory address decoder: a read-only capability word, a global control word, and one decoder set made of a 64-bit base, a 64-bit size, a control word and a 64-bit target list. It sits behind a simple 32-bit register bus. A request is a one-cycle strobe carrying a word address, byte enables, a write flag and a wide-access flag. The response comes back on the next cycle.

Every register has a fixed per-bit write mask. A write stores only the writable bits and leaves every other bit at its old value. The decoder control word handles a commit. If a write to it has the commit bit set, the block stores the masked value and, in the same update, changes the commit bit into a committed status.

Register data is little-endian: byte lane k of the data bus is bits [8k+7:8k]. Only whole 32-bit accesses reach the registers. A 64-bit access is reported as unsupported, and an access with any byte enable low is reported as an error. Neither one changes any register.

Top module: `hdm_decoder_regs`

## Requirements
- R1: Synchronous active-low reset clears the response outputs. After reset, every register except the capability word reads zero, including the global decoder-enable bit (bit 0 of word 1).
- R2: Word map: 1 global control, 2 base low, 3 base high, 4 size low, 5 size high, 6 decoder control, 7 target list low, 8 target list high. A full write stores (data & mask) | (old & ~mask). The masks are 0x0000_0003 (word 1), 0xF000_0000 (words 2 and 4), 0xFFFF_FFFF (words 3 and 5) and 0x0000_13FF (word 6).
- R3: The target list low mask is 0xF000_0000 when parameter IS_DEVICE is 1 and 0xFFFF_FFFF when it is 0. Target list high (word 8) is fully writable.
- R4: A full write to word 6 with bit 9 (commit) set stores the masked value. In the same update it clears bit 9, clears bit 11 (error) and sets bit 10 (committed).
- R5: A full write to word 6 with bit 9 clear is a plain masked store. Bits 10 and 11 keep their previous values.
- R6: Word 0 is the capability word and is read-only with value 0x0000_0310. Its fields are: decoder count code 0 (one decoder) in bits [3:0], target count 1 in bits [7:4], 256-byte interleave supported in bit 8, 4 KiB interleave supported in bit 9, and poison-on-error unsupported in bit 10.
- R7: A request with req_wide=1 sets rsp_unsup on the next cycle, returns zero read data and changes no register.
- R8: A request with req_wide=0 and req_be other than 4'hF sets rsp_be_err on the next cycle, returns zero read data and changes no register.
- R9: rsp_valid follows req_valid by exactly one cycle. A full read returns the addressed word on that cycle, and a write returns zero data. Word addresses 9 and above read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle access strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | Access is 8 bytes wide |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte enables, lane 0 lowest address |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| rsp_unsup | output | 1 | Wide access was rejected |
| rsp_be_err | output | 1 | Partial byte enables were rejected |

## Verification
The assertions assume that req_be, req_wide and req_write are stable and meaningful only while req_valid is high, and that one request is presented per strobe. The bench drives every field on the falling edge, holds req_valid for exactly one rising edge, and then drops it. This way no property sees a half-formed request. The sweep covers every address, including the unmapped ones. It uses data patterns that set the commit bit and patterns that clear it, and it runs wide and partial-enable requests against mapped words. The register values the assertions compare are therefore only disturbed by legal full writes.

// File: rtl/hdm_regs_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, register indices, write masks and the
// request classification type for the decoder register block.
package hdm_regs_pkg;

    localparam int REG_W    = 32;
    localparam int BE_W     = REG_W / 8;
    localparam int NUM_REGS = 9;

    localparam int IDX_CAP     = 0;
    localparam int IDX_GCTL    = 1;
    localparam int IDX_BASE_LO = 2;
    localparam int IDX_BASE_HI = 3;
    localparam int IDX_SIZE_LO = 4;
    localparam int IDX_SIZE_HI = 5;
    localparam int IDX_DCTL    = 6;
    localparam int IDX_TGT_LO  = 7;
    localparam int IDX_TGT_HI  = 8;

    // Control word bit positions; the write mask depends on them.
    localparam int CTL_COMMIT_BIT    = 9;
    localparam int CTL_COMMITTED_BIT = 10;
    localparam int CTL_ERR_BIT       = 11;

    // Capability: one decoder (code 0), target count 1, 256B and 4KiB
    // interleave supported, poison-on-error unsupported.
    localparam logic [REG_W-1:0] CAP_VALUE = 32'h0000_0310;

    // Bits of the control word that hardware alone may change.
    localparam logic [REG_W-1:0] CTL_STATUS_BITS =
        (32'h1 << CTL_COMMITTED_BIT) | (32'h1 << CTL_ERR_BIT);

    // Per-register write mask; the target-list-low mask depends on role.
    function automatic logic [REG_W-1:0] wmask_of(input int idx, input bit is_dev);
        logic [REG_W-1:0] m;
        case (idx)
            IDX_GCTL:    m = 32'h0000_0003;
            IDX_BASE_LO: m = 32'hF000_0000;
            IDX_BASE_HI: m = 32'hFFFF_FFFF;
            IDX_SIZE_LO: m = 32'hF000_0000;
            IDX_SIZE_HI: m = 32'hFFFF_FFFF;
            IDX_DCTL:    m = 32'h0000_13FF;
            IDX_TGT_LO:  m = is_dev ? 32'hF000_0000 : 32'hFFFF_FFFF;
            IDX_TGT_HI:  m = 32'hFFFF_FFFF;
            default:     m = 32'h0000_0000;
        endcase
        return m;
    endfunction

    // Outcome of one bus request.
    typedef struct packed {
        logic unsup;   // wide access rejected
        logic be_err;  // partial byte enables rejected
        logic wr_ok;   // full write accepted
        logic rd_ok;   // full read accepted
    } acc_class_t;

endpackage

// File: rtl/hdm_access_check.sv
`timescale 1ns/1ps
// Access classifier: sorts a bus request into accepted read, accepted
// write, rejected wide access or rejected partial access.
// Assumes the request fields are meaningful only while req_valid is high.
module hdm_access_check
    import hdm_regs_pkg::*;
(
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            req_wide,
    input  logic [BE_W-1:0] req_be,
    output acc_class_t      cls
);

    logic full_be;

    // Purpose: a legal access enables every byte lane.
    assign full_be = &req_be;

    // Purpose: derive the mutually exclusive request outcomes.
    always_comb begin
        cls.unsup  = req_valid &  req_wide;
        cls.be_err = req_valid & ~req_wide & ~full_be;
        cls.wr_ok  = req_valid & ~req_wide &  full_be &  req_write;
        cls.rd_ok  = req_valid & ~req_wide &  full_be & ~req_write;
    end

endmodule

// File: rtl/hdm_commit_merge.sv
`timescale 1ns/1ps
// Masked merge: computes the next register value from the old value and
// write data through a fixed mask. The commit variant also turns a set
// commit bit into committed status in the same update.
// Assumes MASK excludes the committed and error bits for the commit variant.
module hdm_commit_merge
    import hdm_regs_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK       = '0,
    parameter bit               HAS_COMMIT = 1'b0
) (
    input  logic [REG_W-1:0] old_q,
    input  logic [REG_W-1:0] new_d,
    output logic [REG_W-1:0] next_q
);

    logic [REG_W-1:0] merged;

    // Purpose: writable bits from new data, read-only bits from old value.
    assign merged = (new_d & MASK) | (old_q & ~MASK);

    if (HAS_COMMIT) begin : g_commit
        // Purpose: apply the commit handshake on top of the masked store.
        always_comb begin
            next_q = merged;
            if (new_d[CTL_COMMIT_BIT]) begin
                next_q[CTL_COMMIT_BIT]    = 1'b0;
                next_q[CTL_ERR_BIT]       = 1'b0;
                next_q[CTL_COMMITTED_BIT] = 1'b1;
            end
        end
    end else begin : g_plain
        assign next_q = merged;
    end

endmodule

// File: rtl/hdm_reg_slot.sv
`timescale 1ns/1ps
// One writable register: resets to zero and loads its masked next value
// on an accepted write aimed at it.
// Assumes wr_en is a single-cycle strobe qualified by the top.
module hdm_reg_slot
    import hdm_regs_pkg::*;
#(
    parameter int IDX       = IDX_GCTL,
    parameter bit IS_DEVICE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    localparam logic [REG_W-1:0] MASK       = wmask_of(IDX, IS_DEVICE);
    localparam bit               HAS_COMMIT = (IDX == IDX_DCTL);
    localparam logic [REG_W-1:0] HW_BITS    = HAS_COMMIT ? CTL_STATUS_BITS : '0;

    logic [REG_W-1:0] next_q;

    hdm_commit_merge #(
        .MASK       (MASK),
        .HAS_COMMIT (HAS_COMMIT)
    ) u_merge (
        .old_q  (q),
        .new_d  (wdata),
        .next_q (next_q)
    );

    // Purpose: register storage with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= next_q;
    end

    // R2: bits outside the mask never move on a write, except hardware status.
    assert_ro_bits_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~(MASK | HW_BITS)) == '0));

    // R2: a register that is not written keeps its value.
    assert_untouched_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (q == $past(q)));

    if (HAS_COMMIT) begin : g_commit_chk
        // R4: commit write leaves committed set, commit and error clear.
        assert_commit_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wdata[CTL_COMMIT_BIT]) |=>
                (q[CTL_COMMITTED_BIT] && !q[CTL_COMMIT_BIT] && !q[CTL_ERR_BIT]));

        // R5: plain control write preserves the status bits.
        assert_plain_keeps_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wdata[CTL_COMMIT_BIT]) |=>
                (q[CTL_COMMITTED_BIT] == $past(q[CTL_COMMITTED_BIT]) &&
                 q[CTL_ERR_BIT] == $past(q[CTL_ERR_BIT])));
    end

endmodule

// File: rtl/hdm_decoder_regs.sv
`timescale 1ns/1ps
// Decoder register block top: classifies bus requests, routes accepted
// writes to the addressed register slot, and returns a registered response
// one cycle after each strobe.
// Assumes one request per req_valid cycle; ADDR_W covers all nine words.
module hdm_decoder_regs
    import hdm_regs_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter bit IS_DEVICE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [REG_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic              rsp_unsup,
    output logic              rsp_be_err
);

    localparam int FLAT_W = NUM_REGS * REG_W;

    acc_class_t       cls;
    logic [REG_W-1:0] words [NUM_REGS];
    logic [FLAT_W-1:0] regs_flat;
    logic [REG_W-1:0] rd_word;

    hdm_access_check u_check (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wide  (req_wide),
        .req_be    (req_be),
        .cls       (cls)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == IDX_CAP) begin : g_const
            // Purpose: capability is a constant, no storage needed.
            assign words[i] = CAP_VALUE;
        end else begin : g_slot
            logic wr_sel;
            // Purpose: strobe this slot on an accepted write to its address.
            assign wr_sel = cls.wr_ok && (req_addr == ADDR_W'(i));
            hdm_reg_slot #(
                .IDX       (i),
                .IS_DEVICE (IS_DEVICE)
            ) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_sel),
                .wdata (req_wdata),
                .q     (words[i])
            );
        end
        // Purpose: flat view of all registers for whole-state checks.
        assign regs_flat[i*REG_W +: REG_W] = words[i];
    end

    // Purpose: select the addressed word; unmapped addresses read zero.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (req_addr == ADDR_W'(k))
                rd_word = words[k];
        end
    end

    // Purpose: register the response one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_unsup  <= 1'b0;
            rsp_be_err <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_rdata  <= cls.rd_ok ? rd_word : '0;
            rsp_unsup  <= cls.unsup;
            rsp_be_err <= cls.be_err;
        end
    end

    // R7: wide access flags unsupported, returns zero and changes nothing.
    assert_wide_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wide) |=>
            (rsp_unsup && !rsp_be_err && rsp_rdata == '0 && $stable(regs_flat)));

    // R8: partial byte enables flag an error and change nothing.
    assert_partial_be_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_wide && req_be != '1) |=>
            (rsp_be_err && !rsp_unsup && rsp_rdata == '0 && $stable(regs_flat)));

    // R9: response strobe follows the request strobe by one cycle.
    assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_unsup && !rsp_be_err));

    // R6: capability word never moves.
    assert_cap_const_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(regs_flat[REG_W-1:0]));

endmodule

// File: tb/hdm_decoder_regs_bench.sv
`timescale 1ns/1ps
module hdm_decoder_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [3:0]  req_be = 4'hF;
    logic [31:0] req_wdata = '0;

    logic        d_valid, p_valid, d_unsup, p_unsup, d_err, p_err;
    logic [31:0] d_rdata, p_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [31:0] exp_dev  [9];
    logic [31:0] exp_port [9];

    always #4 clk = ~clk;

    hdm_decoder_regs #(.ADDR_W(4), .IS_DEVICE(1'b1)) u_hdm_decoder_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(d_valid), .rsp_rdata(d_rdata),
        .rsp_unsup(d_unsup), .rsp_be_err(d_err));

    hdm_decoder_regs #(.ADDR_W(4), .IS_DEVICE(1'b0)) u_hdm_decoder_regs_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(p_valid), .rsp_rdata(p_rdata),
        .rsp_unsup(p_unsup), .rsp_be_err(p_err));

    function automatic logic [31:0] mask_of(input int idx, input bit dev);
        case (idx)
            1: return 32'h0000_0003;
            2, 4: return 32'hF000_0000;
            3, 5, 8: return 32'hFFFF_FFFF;
            6: return 32'h0000_13FF;
            7: return dev ? 32'hF000_0000 : 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_next(input int idx, input bit dev,
                                               input logic [31:0] old, input logic [31:0] d);
        logic [31:0] m = mask_of(idx, dev);
        logic [31:0] n = (d & m) | (old & ~m);
        if (idx == 6 && d[9]) begin
            n[9] = 1'b0; n[11] = 1'b0; n[10] = 1'b1;
        end
        return n;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic access(input logic wr, input logic wide, input logic [3:0] be,
                          input logic [3:0] addr, input logic [31:0] d, input string tag);
        logic [31:0] ed = '0;
        logic [31:0] ep = '0;
        bit full = !wide && be == 4'hF;
        if (!wr && full && addr < 9) begin
            ed = exp_dev[addr];
            ep = exp_port[addr];
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_be = be; req_addr = addr; req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check("R9", "rsp_valid dev", {31'b0, d_valid}, 32'd1);
        check("R9", "rsp_valid port", {31'b0, p_valid}, 32'd1);
        check("R7", "unsup dev", {31'b0, d_unsup}, {31'b0, wide});
        check("R8", "be_err dev", {31'b0, d_err}, {31'b0, !wide && be != 4'hF});
        check(tag, "rdata dev", d_rdata, ed);
        check(tag, "rdata port", p_rdata, ep);
        if (wr && full && addr < 9 && addr != 0) begin
            exp_dev[addr]  = model_next(addr, 1'b1, exp_dev[addr], d);
            exp_port[addr] = model_next(addr, 1'b0, exp_port[addr], d);
        end
    endtask

    function automatic string tag_of(input int a, input logic [31:0] d);
        if (a == 0) return "R6";
        if (a == 6) return d[9] ? "R4" : "R5";
        if (a == 7 || a == 8) return "R3";
        if (a >= 9) return "R9";
        return "R2";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5A5_A5A5,
                 32'h5A5A_5A5A, 32'h1234_5678, 32'hFFFF_FDFF};
        exp_dev[0] = 32'h0000_0310;
        exp_port[0] = 32'h0000_0310;
        for (int i = 1; i < 9; i++) begin
            exp_dev[i] = '0;
            exp_port[i] = '0;
        end

        // R1: reset holds responses idle even with a strobe present.
        @(negedge clk);
        req_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "rsp_valid in reset", {31'b0, d_valid}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;

        // R1, R6: reset values of all addresses.
        for (int a = 0; a < 16; a++)
            access(1'b0, 1'b0, 4'hF, 4'(a), 32'h0, a == 0 ? "R6" : "R1");

        // R2-R6, R9: masked write sweep over every address and pattern.
        foreach (pats[p]) begin
            for (int a = 0; a < 16; a++) begin
                access(1'b1, 1'b0, 4'hF, 4'(a), pats[p], tag_of(a, pats[p]));
                access(1'b0, 1'b0, 4'hF, 4'(a), 32'h0, tag_of(a, pats[p]));
            end
        end

        // R7: wide writes and reads leave state unchanged and read zero.
        for (int a = 0; a < 16; a++) begin
            access(1'b1, 1'b1, 4'hF, 4'(a), 32'h0000_0000, "R7");
            access(1'b0, 1'b1, 4'hF, 4'(a), 32'h0, "R7");
            access(1'b0, 1'b0, 4'hF, 4'(a), 32'h0, "R7");
        end

        // R8: every partial enable pattern on several registers.
        for (int be = 0; be < 15; be++) begin
            foreach (pats[p]) begin
                if (p < 4) begin
                    access(1'b1, 1'b0, 4'(be), 4'(p * 2 + 1), 32'h0000_0200, "R8");
                    access(1'b0, 1'b0, 4'(be), 4'(p * 2 + 1), 32'h0, "R8");
                    access(1'b0, 1'b0, 4'hF, 4'(p * 2 + 1), 32'h0, "R8");
                end
            end
        end

        // R4, R5: commit then plain write to the control word.
        access(1'b1, 1'b0, 4'hF, 4'd6, 32'h0000_0000, "R5");
        access(1'b0, 1'b0, 4'hF, 4'd6, 32'h0, "R5");
        access(1'b1, 1'b0, 4'hF, 4'd6, 32'h0000_0E05, "R4");
        access(1'b0, 1'b0, 4'hF, 4'd6, 32'h0, "R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule